// File: doc/BRIEF.md
# Up-Counting Timer with Software Event Strobes

This block is a 16-bit up-counter driven through a prescaler, with a reload limit and two capture/compare channels. Software talks to it over a simple register port: a write strobe, a 4-bit word address, 16-bit write data and a combinational read data bus. A status word gathers the update, trigger, channel and over-capture flags. Each interrupt line is the flag ANDed with its enable bit.

A write-only strobe register lets software fire an update, a trigger or a channel event. It behaves as if the matching hardware event had happened. The strobe bits are held for exactly one cycle and then drop by themselves. Two control bits decide when the update flag is raised. A disable bit suppresses update events altogether. A source-select bit limits the flag to counter wrap-around only.

The prescaler and reload values are written to holding registers. These are copied into the working registers only on an update event. A single-cycle pulse on `trig_i` restarts the counter. Pulses on `cap_i` latch the counter into a channel that is set up as an input.

Register map (word addresses): 0 control, 1 interrupt enable, 2 status, 3 event strobe, 4 channel direction, 5 counter (read), 6 prescaler, 7 reload, 8 channel 0 value, 9 channel 1 value. Unused addresses read 0.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter reads 0, status reads 0, the prescaler reads 0, the reload value reads 16'hFFFF, the event register reads 0 and all interrupt outputs are low.
- R2: While control bit 0 (run) is 1, the counter advances once every PSC+1 clock cycles and goes from the working reload value back to 0. While run is 0 it holds.
- R3: A counter wrap sets status bit 0 (update flag) only when control bit 1 (update disable) is 0, whatever the value of control bit 2 (request source).
- R4: Event bit 0 (forced update) clears the counter and the prescaler count. It sets the update flag only when update disable and request source are both 0. The written prescaler value is kept.
- R5: A one-cycle pulse on `trig_i` clears the counter and sets status bit 6 (trigger flag). It sets the update flag only when update disable and request source are both 0.
- R6: Writes to the prescaler and reload registers take effect only on an update event: a wrap, a forced update or a trigger, each with update disable at 0. While update disable is 1, a wrap still returns the counter to 0 but leaves the working values unchanged.
- R7: Event register bits are bit 0 forced update, bit 1 channel 0 event, bit 2 channel 1 event and bit 6 trigger event. A written 1 acts on the following clock edge and then clears by itself. Zeros have no effect, and the register always reads 0.
- R8: Event bit 6 sets the trigger flag.
- R9: A channel event with the channel as an output (direction bit i = 0 at address 4) sets status bit 1+i and leaves that channel's value unchanged.
- R10: A channel event or a `cap_i[i]` pulse with the channel as an input (direction bit = 1) copies the counter into the channel value and sets status bit 1+i. If bit 1+i was already set, it also sets over-capture bit 9+i.
- R11: With a channel as an output, status bit 1+i is set when the counter advances to a value equal to that channel's value.
- R12: Writing status clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. A hardware set in the same cycle as a clear wins.
- R13: `irq_upd_o` is status bit 0 AND enable bit 0, `irq_cc_o[i]` is status bit 1+i AND enable bit 1+i, and `irq_trg_o` is status bit 6 AND enable bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| trig_i | input | 1 | Trigger pulse, restarts the counter |
| cap_i | input | 2 | Capture pulses, one per channel |
| irq_upd_o | output | 1 | Update interrupt |
| irq_cc_o | output | 2 | Channel interrupts |
| irq_trg_o | output | 1 | Trigger interrupt |

## Verification
The hardest situation to reach from the ports is a hardware flag set landing on the same edge as a software clear of that flag. The bench creates it by writing the trigger strobe and then writing status on the very next edge, which is the edge where the strobe acts. A second hard case is proving that holding registers are not copied while updates are disabled. The bench loads one reload value into the working register, writes a different one into the holding register, and runs across a wrap. The final count differs depending on which limit was used. Randomised prescaler, reload and run-length trials check the count and the wrap flag against a bench model.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int BUS_W = 16;
    localparam int ADR_W = 4;
    localparam int NCH   = 2;

    // register word addresses
    localparam logic [ADR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADR_W-1:0] A_IEN   = 4'd1;
    localparam logic [ADR_W-1:0] A_STAT  = 4'd2;
    localparam logic [ADR_W-1:0] A_EVT   = 4'd3;
    localparam logic [ADR_W-1:0] A_DIR   = 4'd4;
    localparam logic [ADR_W-1:0] A_CNT   = 4'd5;
    localparam logic [ADR_W-1:0] A_PSC   = 4'd6;
    localparam logic [ADR_W-1:0] A_RLD   = 4'd7;
    localparam logic [ADR_W-1:0] A_CHV0  = 4'd8;

    // control bits
    localparam int C_RUN  = 0;
    localparam int C_UDIS = 1;
    localparam int C_USRC = 2;

    // status / event / enable bit positions
    localparam int B_UPD = 0;
    localparam int B_CH0 = 1;
    localparam int B_TRG = 6;
    localparam int B_OV0 = 9;

    localparam logic [BUS_W-1:0] CH_BITS   = BUS_W'((1 << NCH) - 1);
    localparam logic [BUS_W-1:0] EVT_MASK  = (BUS_W'(1) << B_UPD) | (BUS_W'(1) << B_TRG)
                                           | (CH_BITS << B_CH0);
    localparam logic [BUS_W-1:0] STAT_MASK = EVT_MASK | (CH_BITS << B_OV0);

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] psc_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic             adv_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] pc;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t q, d;
    logic tick, at_lim;

    always_comb begin
        d      = q;
        tick   = run_i && (q.pc == psc_i);
        at_lim = (q.cnt == lim_i);
        if (clr_i) begin
            d.pc  = '0;
            d.cnt = '0;
        end else if (run_i) begin
            if (tick) begin
                d.pc  = '0;
                d.cnt = at_lim ? '0 : q.cnt + 1'b1;
            end else begin
                d.pc = q.pc + 1'b1;
            end
        end
        adv_o     = tick && !clr_i;
        wrap_o    = tick && at_lim && !clr_i;
        cnt_nxt_o = d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q.cnt == '0 && q.pc == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(q));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (q.cnt == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_in_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic             adv_i,
    input  logic             cap_hw_i,
    input  logic             sw_evt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] val_o,
    output logic             hit_o
);

    logic [CNT_W-1:0] val_q, val_d;
    logic             grab;

    always_comb begin
        grab  = is_in_i && (cap_hw_i || sw_evt_i);
        val_d = val_q;
        if (grab)
            val_d = cnt_i;
        else if (wr_i && !is_in_i)
            val_d = wdata_i;
        hit_o = is_in_i ? grab : (sw_evt_i || (adv_i && cnt_nxt_i == val_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

    p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_in_i && (cap_hw_i || sw_evt_i)) |=> (val_q == $past(cnt_i)));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [ADR_W-1:0] addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    input  logic             trig_i,
    input  logic [NCH-1:0]   cap_i,
    output logic             irq_upd_o,
    output logic [NCH-1:0]   irq_cc_o,
    output logic             irq_trg_o
);

    typedef struct packed {
        logic [2:0]       ctrl;
        logic [BUS_W-1:0] ien;
        logic [BUS_W-1:0] stat;
        logic [BUS_W-1:0] evt;
        logic [NCH-1:0]   dir;
        logic [CNT_W-1:0] psc_pre;
        logic [CNT_W-1:0] lim_pre;
        logic [CNT_W-1:0] psc_act;
        logic [CNT_W-1:0] lim_act;
    } tmr_st_t;

    tmr_st_t q, d;

    logic             restart, wrap, adv, upd_evt, upd_flag;
    logic             wr_stat, wr_evt;
    logic [BUS_W-1:0] set_v;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic [NCH-1:0]   hit;
    logic [CNT_W-1:0] ch_val [NCH];

    assign restart = q.evt[B_UPD] || trig_i;

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (q.ctrl[C_RUN]),
        .clr_i    (restart),
        .psc_i    (q.psc_act),
        .lim_i    (q.lim_act),
        .cnt_o    (cnt),
        .cnt_nxt_o(cnt_nxt),
        .adv_o    (adv),
        .wrap_o   (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_in_i  (q.dir[i]),
            .cnt_i    (cnt),
            .cnt_nxt_i(cnt_nxt),
            .adv_i    (adv),
            .cap_hw_i (cap_i[i]),
            .sw_evt_i (q.evt[B_CH0+i]),
            .wr_i     (wr_en_i && addr_i == A_CHV0 + ADR_W'(i)),
            .wdata_i  (wdata_i[CNT_W-1:0]),
            .val_o    (ch_val[i]),
            .hit_o    (hit[i])
        );
    end

    always_comb begin
        d        = q;
        wr_stat  = wr_en_i && addr_i == A_STAT;
        wr_evt   = wr_en_i && addr_i == A_EVT;
        upd_evt  = !q.ctrl[C_UDIS] && (wrap || restart);
        upd_flag = !q.ctrl[C_UDIS] && (wrap || (restart && !q.ctrl[C_USRC]));

        set_v         = '0;
        set_v[B_UPD]  = upd_flag;
        set_v[B_TRG]  = q.evt[B_TRG] || trig_i;
        for (int i = 0; i < NCH; i++) begin
            set_v[B_CH0+i] = hit[i];
            set_v[B_OV0+i] = hit[i] && q.dir[i] && q.stat[B_CH0+i];
        end

        d.stat = ((wr_stat ? (q.stat & wdata_i) : q.stat) | set_v) & STAT_MASK;
        d.evt  = wr_evt ? (wdata_i & EVT_MASK) : '0;

        if (wr_en_i) begin
            case (addr_i)
                A_CTRL: d.ctrl    = wdata_i[2:0];
                A_IEN:  d.ien     = wdata_i & EVT_MASK;
                A_DIR:  d.dir     = wdata_i[NCH-1:0];
                A_PSC:  d.psc_pre = wdata_i[CNT_W-1:0];
                A_RLD:  d.lim_pre = wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end

        if (upd_evt) begin
            d.psc_act = q.psc_pre;
            d.lim_act = q.lim_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.lim_pre <= '1;
            q.lim_act <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: rdata_o = BUS_W'(q.ctrl);
            A_IEN:  rdata_o = q.ien;
            A_STAT: rdata_o = q.stat;
            A_DIR:  rdata_o = BUS_W'(q.dir);
            A_CNT:  rdata_o = BUS_W'(cnt);
            A_PSC:  rdata_o = BUS_W'(q.psc_pre);
            A_RLD:  rdata_o = BUS_W'(q.lim_pre);
            default: ;
        endcase
        for (int i = 0; i < NCH; i++)
            if (addr_i == A_CHV0 + ADR_W'(i)) rdata_o = BUS_W'(ch_val[i]);
    end

    assign irq_upd_o = q.stat[B_UPD] && q.ien[B_UPD];
    assign irq_trg_o = q.stat[B_TRG] && q.ien[B_TRG];
    for (genvar i = 0; i < NCH; i++) begin : g_irq
        assign irq_cc_o[i] = q.stat[B_CH0+i] && q.ien[B_CH0+i];

        p_overcap_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.stat[B_OV0+i]) |-> $past(q.stat[B_CH0+i]));
    end

    p_evt_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.evt != '0 && !wr_evt) |=> (q.evt == '0));

    p_udis_noflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl[C_UDIS] && !q.stat[B_UPD]) |=> !q.stat[B_UPD]);

    p_udis_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.ctrl[C_UDIS] |=> $stable(q.lim_act));

endmodule

// File: tb/tb_evt_timer.sv
module tb_evt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        trig = 1'b0;
    logic [1:0]  cap = 2'b00;
    logic        irq_upd, irq_trg;
    logic [1:0]  irq_cc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .trig_i(trig), .cap_i(cap),
        .irq_upd_o(irq_upd), .irq_cc_o(irq_cc), .irq_trg_o(irq_trg)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic strobe(logic [15:0] v);
        wr(4'd3, v);
        @(negedge clk);
    endtask

    task automatic run_edges(int n, logic [15:0] ctl_idle);
        wr(4'd0, ctl_idle | 16'h1);
        repeat (n - 1) @(negedge clk);
        wr(4'd0, ctl_idle);
    endtask

    function automatic int exp_cnt(int p, int lim, int n);
        return (n / (p + 1)) % (lim + 1);
    endfunction

    function automatic bit exp_wrap(int p, int lim, int n);
        return (n / (p + 1)) > lim;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd12345));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd5, v); check("R1 cnt", v, 16'h0);
        rd(4'd2, v); check("R1 stat", v, 16'h0);
        rd(4'd6, v); check("R1 psc", v, 16'h0);
        rd(4'd7, v); check("R1 reload", v, 16'hFFFF);
        rd(4'd3, v); check("R1 evt", v, 16'h0);
        check("R1 irq", {12'd0, irq_upd, irq_trg, irq_cc}, 16'h0);

        // R2 basic counting, limit still all ones
        wr(4'd6, 16'd0);
        wr(4'd7, 16'd9);
        run_edges(5, 16'h0);
        rd(4'd5, v); check("R2 count", v, 16'd5);

        // R7 zeros have no effect
        strobe(16'h0000);
        rd(4'd5, v); check("R7 zero cnt", v, 16'd5);
        rd(4'd2, v); check("R7 zero stat", v, 16'h0);

        // R4 forced update
        wr(4'd6, 16'd2);
        strobe(16'h0001);
        rd(4'd5, v); check("R4 cleared", v, 16'd0);
        rd(4'd2, v); check("R4 flag", v, 16'h0001);
        rd(4'd6, v); check("R4 psc kept", v, 16'd2);
        rd(4'd3, v); check("R7 readback", v, 16'h0);

        // R12 write 1 keeps, write 0 clears
        wr(4'd2, 16'hFFFF);
        rd(4'd2, v); check("R12 keep", v, 16'h0001);
        wr(4'd2, 16'hFFFE);
        rd(4'd2, v); check("R12 clear", v, 16'h0);

        // R4 with request source set / disable set
        wr(4'd6, 16'd0);
        wr(4'd0, 16'h4);
        strobe(16'h0001);
        rd(4'd2, v); check("R4 usrc", v, 16'h0);
        wr(4'd0, 16'h2);
        strobe(16'h0001);
        rd(4'd2, v); check("R4 udis", v, 16'h0);

        // R6/R3 holding register blocked while updates disabled
        wr(4'd0, 16'h4);
        wr(4'd7, 16'd3);
        strobe(16'h0001);
        wr(4'd2, 16'h0);
        wr(4'd7, 16'd5);
        run_edges(10, 16'h2);
        rd(4'd5, v); check("R6 old limit", v, 16'd2);
        rd(4'd2, v); check("R3 no flag udis", v & 16'h1, 16'h0);
        // R6/R3 transfer at wrap when enabled (request source set)
        wr(4'd7, 16'd3);
        strobe(16'h0001);
        wr(4'd7, 16'd5);
        wr(4'd2, 16'h0);
        run_edges(10, 16'h4);
        rd(4'd5, v); check("R6 new limit", v, 16'd0);
        rd(4'd2, v); check("R3 wrap flag", v & 16'h1, 16'h1);

        // R2/R3 random trials
        for (int t = 0; t < 24; t++) begin
            int p, lim, n;
            p   = int'($urandom_range(3, 0));
            lim = int'($urandom_range(7, 1));
            n   = int'($urandom_range(30, 1));
            wr(4'd6, 16'(p));
            wr(4'd7, 16'(lim));
            wr(4'd0, 16'h4);
            strobe(16'h0001);
            wr(4'd2, 16'h0);
            run_edges(n, 16'h4);
            rd(4'd5, v); check("R2 random count", v, 16'(exp_cnt(p, lim, n)));
            rd(4'd2, v); check("R3 random wrap", v & 16'h1, 16'(exp_wrap(p, lim, n)));
        end

        // R5 trigger pulse
        wr(4'd0, 16'h0);
        wr(4'd7, 16'd100);
        run_edges(3, 16'h0);
        wr(4'd2, 16'h0);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        rd(4'd5, v); check("R5 cleared", v, 16'd0);
        rd(4'd2, v); check("R5 flags", v & 16'h41, 16'h41);
        wr(4'd0, 16'h4);
        wr(4'd2, 16'h0);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        rd(4'd2, v); check("R5 usrc", v & 16'h41, 16'h40);
        wr(4'd2, 16'h0);

        // R8 / R13 trigger strobe and its interrupt
        strobe(16'h0040);
        rd(4'd2, v); check("R8 trg flag", v, 16'h0040);
        check("R13 trg masked", {15'd0, irq_trg}, 16'h0);
        wr(4'd1, 16'h0047);
        check("R13 trg irq", {15'd0, irq_trg}, 16'h1);
        // R12 set wins over same-edge clear
        wr(4'd2, 16'h0);
        wr(4'd3, 16'h0040);
        wr(4'd2, 16'h0);
        rd(4'd2, v); check("R12 set wins", v, 16'h0040);
        wr(4'd2, 16'h0);
        check("R13 trg low", {15'd0, irq_trg}, 16'h0);

        // R9 output channel event
        wr(4'd4, 16'h0);
        wr(4'd8, 16'h1234);
        strobe(16'h0002);
        rd(4'd2, v); check("R9 ch0 flag", v, 16'h0002);
        rd(4'd8, v); check("R9 ch0 value", v, 16'h1234);
        check("R13 cc irq", {14'd0, irq_cc}, 16'h1);
        wr(4'd2, 16'h0);

        // R13 update interrupt
        wr(4'd0, 16'h0);
        strobe(16'h0001);
        check("R13 upd irq", {15'd0, irq_upd}, 16'h1);
        wr(4'd2, 16'h0);

        // R10 input capture
        wr(4'd4, 16'h3);
        run_edges(7, 16'h0);
        wr(4'd2, 16'h0);
        strobe(16'h0004);
        rd(4'd9, v); check("R10 captured", v, 16'd7);
        rd(4'd2, v); check("R10 flag", v, 16'h0004);
        strobe(16'h0004);
        rd(4'd2, v); check("R10 overcap", v, 16'h0404);
        cap = 2'b01; @(negedge clk); cap = 2'b00;
        rd(4'd8, v); check("R10 hw capture", v, 16'd7);
        rd(4'd2, v); check("R10 hw flag", v & 16'h0202, 16'h0002);
        wr(4'd2, 16'h0);

        // R11 compare match
        wr(4'd4, 16'h0);
        wr(4'd9, 16'd10);
        run_edges(3, 16'h0);
        rd(4'd2, v); check("R11 match", v & 16'h4, 16'h4);
        wr(4'd2, 16'h0);
        wr(4'd9, 16'd20);
        run_edges(3, 16'h0);
        rd(4'd5, v); check("R11 count", v, 16'd13);
        rd(4'd2, v); check("R11 no match", v & 16'h4, 16'h0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule